// File: doc/BRIEF.md
# Serial Frame Transmitter with Break and Idle Generation

This block is the transmit half of an asynchronous serial port. A byte (or a nine-bit word) written into its holding register is shifted out on the serial line, least significant bit first. The word is framed by a low start bit and a high stop bit. Every bit lasts for exactly one interval between pulses of an external bit-rate tick. A select input chooses between eight-bit and nine-bit words, which makes a frame 10 or 11 bit times long. A build parameter can replace the top data slot with an even parity bit.

Besides data, the engine produces two kinds of special frame. A line-break frame holds the line low for a whole frame length. A filler frame holds the line high for a whole frame length. Break frames repeat for as long as the break request is held. When the request drops, a single high bit follows the last break so that the next start edge can be seen. Filler frames are sent in two cases: as a preamble after the enable goes high, and as a queued gap when the enable is dropped and restored while a frame is still going out. When the enable is dropped and not restored, the current frame finishes and the line rests high. Any pending word then waits.

Top module: `frame_tx`

## Requirements
- R1: During and straight after reset, `txd` is high and `tdr_empty` is 1.
- R2: A data frame is: one low start bit, then the data bits LSB first (8 bits when `long_frame`=0, 9 bits when `long_frame`=1), then one high stop bit. That is 10 or 11 bit times. When nothing is pending, `txd` is high afterwards.
- R3: A word written before the stop bit of the frame in flight ends begins with its start bit in the very next bit time, with no gap.
- R4: A write sets `tdr_empty` to 0. `tdr_empty` returns to 1 only on the tick that moves the word into the shift register. If a write lands on that same tick, the old word is sent, the new word is kept, and `tdr_empty` stays 0.
- R5: When `tx_en` rises while the line is quiet, a filler frame goes out first: `txd` high for a full frame length. Any pending word starts only after it.
- R6: While `brk_req` is 1 (and `tx_en` is 1), the line carries back-to-back break frames. Each is low for a full frame length (10 or 11 bit times) and has no start or stop bit. A pending word waits.
- R7: After `brk_req` drops, the break in progress completes. Exactly one high bit time follows, and then any pending word starts.
- R8: If `tx_en` is cleared and set again while a frame is going out, before its stop bit is on the line, one filler frame (high, full frame length) follows that frame. A pending word follows the filler frame.
- R9: If `tx_en` is set again only once the stop bit is already on the line, no filler frame is inserted and a pending word follows directly.
- R10: If `tx_en` is cleared during a frame and stays low, the frame completes and `txd` then stays high. A pending word is held (`tdr_empty` stays 0) until the enable returns, and it then goes out after the preamble filler frame.
- R11: `txd` changes only in the cycle after a `bit_tick` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable |
| brk_req | input | 1 | Request for continuous break frames |
| long_frame | input | 1 | 0: 8 data bits, 1: 9 data bits |
| wr_stb | input | 1 | Holding-register write strobe |
| wr_data | input | DATA_W (9) | Word to send; bit 8 is ignored when `long_frame`=0 |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| txd | output | 1 | Serial output, high when idle |
| tdr_empty | output | 1 | Holding register can take a new word |

## Verification
The two events that can share a cycle are a write to the holding register and the bit tick that moves the current word into the shift register. The bench raises `wr_stb` and `bit_tick` on the same edge. It then expects `tdr_empty` to stay 0, the earlier word to go out first, and the newly written word to follow it back to back. A second collision is an enable edge that coincides with the stop bit. The bench restores `tx_en` either before or during the stop bit and judges, bit by bit on `txd`, whether a filler frame was inserted.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;

    // Kind of frame held in (or about to enter) the shift register.
    typedef enum logic [2:0] {
        FK_NONE  = 3'd0,
        FK_DATA  = 3'd1,
        FK_BREAK = 3'd2,
        FK_IDLE  = 3'd3,
        FK_MARK  = 3'd4
    } frame_kind_e;

    // Line level that a solid (non-data) frame carries for its whole length.
    function automatic logic solid_level(input frame_kind_e kind);
        return (kind == FK_BREAK) ? 1'b0 : 1'b1;
    endfunction

endpackage

// File: rtl/frame_tx_holding.sv
module frame_tx_holding #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_empty
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_data  <= '0;
            hold_empty <= 1'b1;
        end else if (wr_stb) begin
            // A write on the transfer tick wins: the old word has already
            // been copied into the shifter this cycle.
            hold_data  <= wr_data;
            hold_empty <= 1'b0;
        end else if (take) begin
            hold_empty <= 1'b1;
        end
    end

endmodule

// File: rtl/frame_tx_sequencer.sv
module frame_tx_sequencer
    import frame_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bit_tick,
    input  logic        tx_en,
    input  logic        brk_req,
    input  logic        hold_empty,
    input  logic        busy,
    input  logic        last,
    output logic        start,
    output frame_kind_e next_kind,
    output logic        take
);

    logic en_d;
    logic idle_owed;
    logic mark_owed;
    logic slot;
    logic rise;
    logic rise_ok;
    logic idle_req;

    // A frame boundary: line quiet, or the final bit of a frame ends now.
    assign slot     = bit_tick && (!busy || last);
    assign rise     = tx_en && !en_d;
    // An enable edge that arrives while the stop bit is on the line is lost.
    assign rise_ok  = rise && !(busy && last);
    assign idle_req = idle_owed || rise_ok;

    always_comb begin
        next_kind = FK_NONE;
        if (tx_en) begin
            if (idle_req) begin
                next_kind = FK_IDLE;
            end else if (brk_req) begin
                next_kind = FK_BREAK;
            end else if (mark_owed) begin
                next_kind = FK_MARK;
            end else if (!hold_empty) begin
                next_kind = FK_DATA;
            end
        end
    end

    assign start = slot && (next_kind != FK_NONE);
    assign take  = slot && (next_kind == FK_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_d      <= 1'b0;
            idle_owed <= 1'b0;
            mark_owed <= 1'b0;
        end else begin
            en_d <= tx_en;
            if (slot) begin
                idle_owed <= 1'b0;
                mark_owed <= (next_kind == FK_BREAK);
            end else if (rise_ok) begin
                idle_owed <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/frame_tx_shifter.sv
module frame_tx_shifter
    import frame_tx_pkg::*;
#(
    parameter int DATA_W    = 9,
    parameter bit PARITY_EN = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              start,
    input  frame_kind_e       start_kind,
    input  logic              long_frame,
    input  logic [DATA_W-1:0] data,
    output logic              busy,
    output logic              last,
    output frame_kind_e       cur_kind,
    output logic              txd
);

    localparam int FRAME_W = DATA_W + 2;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] sr;
    logic [FRAME_W-1:0] load_img;
    logic [CNT_W-1:0]   left;
    logic [CNT_W-1:0]   load_len;
    logic [DATA_W-1:0]  payload;

    generate
        if (PARITY_EN) begin : g_parity
            always_comb begin
                payload = data;
                if (long_frame) begin
                    payload[DATA_W-1] = ^data[DATA_W-2:0];
                end else begin
                    payload[DATA_W-2] = ^data[DATA_W-3:0];
                end
            end
        end else begin : g_plain
            assign payload = data;
        end
    endgenerate

    always_comb begin
        load_img = {FRAME_W{solid_level(start_kind)}};
        load_len = long_frame ? CNT_W'(FRAME_W) : CNT_W'(FRAME_W - 1);
        case (start_kind)
            FK_DATA: begin
                load_img[0] = 1'b0;
                for (int i = 0; i < DATA_W; i++) begin
                    if (long_frame || (i < DATA_W - 1)) begin
                        load_img[i+1] = payload[i];
                    end
                end
            end
            FK_MARK: load_len = CNT_W'(1);
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr       <= '1;
            left     <= '0;
            cur_kind <= FK_NONE;
        end else if (start) begin
            sr       <= load_img;
            left     <= load_len;
            cur_kind <= start_kind;
        end else if (bit_tick && busy) begin
            sr   <= {1'b1, sr[FRAME_W-1:1]};
            left <= left - CNT_W'(1);
            if (last) begin
                cur_kind <= FK_NONE;
            end
        end
    end

    assign busy = (left != '0);
    assign last = (left == CNT_W'(1));
    assign txd  = busy ? sr[0] : 1'b1;

endmodule

// File: rtl/frame_tx.sv
module frame_tx
    import frame_tx_pkg::*;
#(
    parameter int DATA_W    = 9,
    parameter bit PARITY_EN = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              brk_req,
    input  logic              long_frame,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bit_tick,
    output logic              txd,
    output logic              tdr_empty
);

    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              seq_start;
    frame_kind_e       seq_kind;
    logic              sh_busy;
    logic              sh_last;
    frame_kind_e       sh_kind;

    frame_tx_holding #(.DATA_W(DATA_W)) i_holding (
        .clk        (clk),
        .rst        (rst),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .take       (take),
        .hold_data  (hold_data),
        .hold_empty (tdr_empty)
    );

    frame_tx_sequencer i_sequencer (
        .clk        (clk),
        .rst        (rst),
        .bit_tick   (bit_tick),
        .tx_en      (tx_en),
        .brk_req    (brk_req),
        .hold_empty (tdr_empty),
        .busy       (sh_busy),
        .last       (sh_last),
        .start      (seq_start),
        .next_kind  (seq_kind),
        .take       (take)
    );

    frame_tx_shifter #(.DATA_W(DATA_W), .PARITY_EN(PARITY_EN)) i_shifter (
        .clk        (clk),
        .rst        (rst),
        .bit_tick   (bit_tick),
        .start      (seq_start),
        .start_kind (seq_kind),
        .long_frame (long_frame),
        .data       (hold_data),
        .busy       (sh_busy),
        .last       (sh_last),
        .cur_kind   (sh_kind),
        .txd        (txd)
    );

endmodule

// File: rtl/frame_tx_chk.sv
module frame_tx_chk
    import frame_tx_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        bit_tick,
    input logic        brk_req,
    input logic        wr_stb,
    input logic        txd,
    input logic        tdr_empty,
    input logic        busy,
    input logic        last,
    input frame_kind_e kind
);

    logic rst_q = 1'b0;

    always @(posedge clk) begin
        rst_q <= rst;
        if (rst_q) begin
            AST_RESET_STATE: assert (txd && tdr_empty); // R1
        end
    end

    AST_TXD_HOLDS_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |=> $stable(txd)); // R11

    AST_WRITE_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !tdr_empty); // R4

    AST_EMPTY_SETS_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (!tdr_empty && !bit_tick) |=> !tdr_empty); // R4

    AST_BREAK_FRAME_LOW: assert property (@(posedge clk) disable iff (rst)
        (busy && kind == FK_BREAK) |-> !txd); // R6

    AST_IDLE_FRAME_HIGH: assert property (@(posedge clk) disable iff (rst)
        (busy && kind == FK_IDLE) |-> txd); // R5

    AST_MARK_AFTER_BREAK: assert property (@(posedge clk) disable iff (rst)
        (busy && last && kind == FK_BREAK && bit_tick && !brk_req) |=> txd); // R7

endmodule

bind frame_tx frame_tx_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_tick  (bit_tick),
    .brk_req   (brk_req),
    .wr_stb    (wr_stb),
    .txd       (txd),
    .tdr_empty (tdr_empty),
    .busy      (sh_busy),
    .last      (sh_last),
    .kind      (sh_kind)
);

// File: tb/test_frame_tx.sv
module test_frame_tx;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_en = 1'b0;
    logic       brk_req = 1'b0;
    logic       long_frame = 1'b0;
    logic       wr_stb = 1'b0;
    logic [8:0] wr_data = '0;
    logic       bit_tick = 1'b0;
    logic       txd;
    logic       tdr_empty;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    frame_tx i_frame_tx (
        .clk        (clk),
        .rst        (rst),
        .tx_en      (tx_en),
        .brk_req    (brk_req),
        .long_frame (long_frame),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .bit_tick   (bit_tick),
        .txd        (txd),
        .tdr_empty  (tdr_empty)
    );

    task automatic check(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    // One bit time: a single-cycle tick, then settle before sampling.
    task automatic tick();
        @(negedge clk) bit_tick = 1'b1;
        @(negedge clk) bit_tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic write(input logic [8:0] d);
        @(negedge clk) begin wr_stb = 1'b1; wr_data = d; end
        @(negedge clk) wr_stb = 1'b0;
    endtask

    function automatic logic [10:0] mk(input logic [8:0] d, input logic m);
        logic [10:0] f;
        f    = '1;
        f[0] = 1'b0;
        for (int i = 0; i < 9; i++) begin
            if (m || i < 8) f[i+1] = d[i];
        end
        return f;
    endfunction

    task automatic exp_bits(input logic [10:0] b, input int n, input int from, input string req);
        for (int i = from; i < n; i++) begin
            tick();
            check(txd, b[i], req, $sformatf("bit %0d", i));
        end
    endtask

    task automatic exp_level(input logic lvl, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            tick();
            check(txd, lvl, req, $sformatf("solid bit %0d", i));
        end
    endtask

    task automatic sweep(input logic m);
        int lim;
        int n;
        lim = m ? 512 : 256;
        n   = m ? 11 : 10;
        long_frame = m;
        write(9'd0);
        for (int v = 0; v < lim; v++) begin
            tick();
            check(txd, 1'b0, "R3", "start without gap");
            check(tdr_empty, 1'b1, "R4", "empty after transfer");
            if (v + 1 < lim) write(9'(v + 1));
            exp_bits(mk(9'(v), m), n, 1, "R2");
        end
        tick();
        check(txd, 1'b1, "R2", "line high after last frame");
    endtask

    task automatic break_case(input logic m, input logic [8:0] d);
        int n;
        n = m ? 11 : 10;
        long_frame = m;
        brk_req = 1'b1;
        exp_level(1'b0, 1, "R6");
        write(d);
        exp_level(1'b0, n - 1, "R6");
        check(tdr_empty, 1'b0, "R6", "word waits during break");
        for (int i = 0; i < n; i++) begin
            tick();
            check(txd, 1'b0, "R6", "second break");
            if (i == 2) brk_req = 1'b0;
        end
        tick();
        check(txd, 1'b1, "R7", "mark after break");
        exp_bits(mk(d, m), n, 0, "R7");
        tick();
        check(txd, 1'b1, "R2", "quiet after frame");
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual still running expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(txd, 1'b1, "R1", "txd in reset");
        check(tdr_empty, 1'b1, "R1", "empty in reset");
        rst = 1'b0;
        @(negedge clk);
        check(txd, 1'b1, "R1", "txd after reset");
        check(tdr_empty, 1'b1, "R1", "empty after reset");

        // Preamble after enable, then the first word (R5, R4, R2).
        tx_en = 1'b1;
        write(9'h03C);
        check(tdr_empty, 1'b0, "R4", "write clears empty");
        exp_level(1'b1, 10, "R5");
        check(tdr_empty, 1'b0, "R5", "word held behind preamble");
        tick();
        check(txd, 1'b0, "R5", "start right after preamble");
        check(tdr_empty, 1'b1, "R4", "empty sets on transfer");
        exp_bits(mk(9'h03C, 1'b0), 10, 1, "R2");
        tick();
        check(txd, 1'b1, "R2", "quiet after frame");

        // Every word value in both lengths, back to back (R2, R3).
        sweep(1'b0);
        sweep(1'b1);

        // Write on the same tick as the transfer (R4).
        long_frame = 1'b0;
        write(9'h0A5);
        @(negedge clk) begin bit_tick = 1'b1; wr_stb = 1'b1; wr_data = 9'h05A; end
        @(negedge clk) begin bit_tick = 1'b0; wr_stb = 1'b0; end
        @(negedge clk);
        @(negedge clk);
        check(tdr_empty, 1'b0, "R4", "collision keeps new word");
        check(txd, 1'b0, "R4", "old word starts");
        exp_bits(mk(9'h0A5, 1'b0), 10, 1, "R4");
        exp_bits(mk(9'h05A, 1'b0), 10, 0, "R4");
        tick();
        check(txd, 1'b1, "R2", "quiet after pair");

        // Breaks in both lengths (R6, R7).
        break_case(1'b0, 9'h0C3);
        break_case(1'b1, 9'h1E1);

        // Enable toggled before the stop bit: filler frame queued (R8).
        long_frame = 1'b0;
        write(9'h081);
        tick();
        write(9'h042);
        exp_bits(mk(9'h081, 1'b0), 4, 1, "R8");
        tx_en = 1'b0;
        exp_bits(mk(9'h081, 1'b0), 5, 4, "R8");
        tx_en = 1'b1;
        exp_bits(mk(9'h081, 1'b0), 10, 5, "R8");
        exp_level(1'b1, 10, "R8");
        exp_bits(mk(9'h042, 1'b0), 10, 0, "R8");
        tick();
        check(txd, 1'b1, "R8", "quiet after");

        // Enable restored during the stop bit: no filler (R9).
        write(9'h0F0);
        tick();
        write(9'h00F);
        exp_bits(mk(9'h0F0, 1'b0), 4, 1, "R9");
        tx_en = 1'b0;
        exp_bits(mk(9'h0F0, 1'b0), 10, 4, "R9");
        tx_en = 1'b1;
        exp_bits(mk(9'h00F, 1'b0), 10, 0, "R9");
        tick();
        check(txd, 1'b1, "R9", "quiet after");

        // Enable dropped and left low: word held, then preamble (R10).
        write(9'h099);
        tick();
        write(9'h066);
        exp_bits(mk(9'h099, 1'b0), 3, 1, "R10");
        tx_en = 1'b0;
        exp_bits(mk(9'h099, 1'b0), 10, 3, "R10");
        exp_level(1'b1, 12, "R10");
        check(tdr_empty, 1'b0, "R10", "word held while disabled");
        tx_en = 1'b1;
        exp_level(1'b1, 10, "R10");
        exp_bits(mk(9'h066, 1'b0), 10, 0, "R10");
        check(tdr_empty, 1'b1, "R10", "held word sent");

        // Output steady between ticks (R11).
        write(9'h001);
        @(negedge clk) bit_tick = 1'b1;
        @(negedge clk) bit_tick = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(txd, 1'b0, "R11", "start bit steady between ticks");
        end
        exp_bits(mk(9'h001, 1'b0), 10, 1, "R11");

        summary();
        $finish;
    end

endmodule